// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is the serial chain of test cells that sits between a device's pads and its core logic. Every input pad owns one cell. Every output pad owns two cells: a data cell that supplies the pad value and a control cell that supplies the pad's output enable. Each cell has a shift stage and an update latch. The shift stages form one serial path from `tdi` to `tdo`. The update latches hold the values that are applied in parallel.

The test access logic outside this block drives it. That logic supplies three strobes (capture, shift and update), a two-bit mode code and the serial input bit. The block does not decode instructions and does not sequence states.

The mode code selects one of four behaviours. In functional mode the block is transparent. In sample/preload mode it observes the signals while the pads stay under functional control. In external test mode the pads are driven from the latches. In internal test mode the core inputs are driven from the latches.

Top module: `bsc_chain`

## Requirements
- R1: While `rstN` is low, every shift stage and every update latch is cleared asynchronously. As a result, `tdo` reads 0, and in a test mode the pads show value 0 with the enable at 0.
- R2: Mode code 00 is functional. In this mode `padOut` follows `coreTx`, `padOutEn` follows `coreTxEn` and `coreRx` follows `padIn`. Capture, shift and update strobes have no effect on any cell.
- R3: Mode code 01 is sample/preload. In this mode the pads and core keep the functional paths of R2. A capture strobe seen at a rising `tck` loads the shift stages from the live signals. Input pad k is held in cell k. Output pad j keeps its data (`coreTx[j]`) in cell IN_PINS+2j and its enable (`coreTxEn[j]`) in cell IN_PINS+2j+1.
- R4: When the mode code is not 00, each rising `tck` with the shift strobe high moves every shift stage one place toward `tdo`. Cell 0 takes `tdi`, and `tdo` always shows the last cell. No more than one strobe is high at a time.
- R5: When the mode code is not 00, an update strobe copies all shift stages into the update latches on the falling edge of `tck`. At all other times the latches hold their values, so pad values do not change during capture or shift.
- R6: Latch values loaded in sample/preload mode appear on `padOut` and `padOutEn` as soon as the mode code changes to 10. No further update is needed.
- R7: Mode code 10 is external test. In this mode `padOut[j]` is the data latch of output j and `padOutEn[j]` is its control latch. `coreRx` still follows `padIn`.
- R8: Mode code 11 is internal test. In this mode `coreRx[k]` is the latch of input cell k. The pads are driven from the latches as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; shift stages use the rising edge, latches use the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Mode code: 00 functional, 01 sample/preload, 10 external test, 11 internal test |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data into cell 0 |
| padIn | input | IN_PINS | Values arriving at the input pads |
| coreRx | output | IN_PINS | Input values delivered to the core |
| coreTx | input | OUT_PINS | Output data from the core |
| coreTxEn | input | OUT_PINS | Output enables from the core |
| padOut | output | OUT_PINS | Data driven to the output pads |
| padOutEn | output | OUT_PINS | Enables driven to the output pads |
| tdo | output | 1 | Serial data from the last cell |

## Verification
The assertions assume the following about the inputs:
- The three strobes are mutually exclusive.
- The mode code and strobes change only between clock edges, so one value holds across both the rising and the falling edge of a cycle. Under this assumption, a single-cycle stability check on the latches at falling edges expresses R5.

The stimulus stays within these rules by using one stepping routine. That routine sets all inputs a quarter period after a rising edge, sets at most one strobe, and clears it one full period later.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'b00,
    MODE_SAMPLE = 2'b01,
    MODE_EXT    = 2'b10,
    MODE_INT    = 2'b11
  } scanMode_e;

  typedef struct packed {
    logic capEn;
    logic shiftEn;
    logic updEn;
    logic padFromLatch;
    logic coreFromLatch;
  } cellCtl_t;

endpackage

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
  import bsc_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  output cellCtl_t   ctl
);

  scanMode_e mode;
  logic      active;

  assign mode   = scanMode_e'(modeSel);
  assign active = (mode != MODE_FUNC);

  always_comb begin
    ctl.capEn         = active & captureDr;
    ctl.shiftEn       = active & shiftDr & ~captureDr;
    ctl.updEn         = active & updateDr;
    ctl.padFromLatch  = (mode == MODE_EXT) || (mode == MODE_INT);
    ctl.coreFromLatch = (mode == MODE_INT);
  end

endmodule

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int NI = 3,
  parameter int NO = 2
) (
  input  logic                   tck,
  input  logic                   rstN,
  input  cellCtl_t               ctl,
  input  logic                   tdi,
  input  logic [NI-1:0]          padIn,
  input  logic [NO-1:0]          coreTx,
  input  logic [NO-1:0]          coreTxEn,
  output logic [NI-1:0]          coreRx,
  output logic [NO-1:0]          padOut,
  output logic [NO-1:0]          padOutEn,
  output logic                   tdo,
  output logic [NI+2*NO-1:0]     shiftQ,
  output logic [NI+2*NO-1:0]     updQ
);

  localparam int LEN = NI + 2 * NO;

  logic [LEN-1:0] capVec;
  logic [LEN-1:0] shiftNext;

  for (genvar k = 0; k < NI; k++) begin : g_inCell
    assign capVec[k] = padIn[k];
    assign coreRx[k] = ctl.coreFromLatch ? updQ[k] : padIn[k];
  end

  for (genvar j = 0; j < NO; j++) begin : g_outCell
    localparam int DATA_IDX = NI + 2 * j;
    localparam int CTRL_IDX = NI + 2 * j + 1;
    assign capVec[DATA_IDX] = coreTx[j];
    assign capVec[CTRL_IDX] = coreTxEn[j];
    assign padOut[j]   = ctl.padFromLatch ? updQ[DATA_IDX] : coreTx[j];
    assign padOutEn[j] = ctl.padFromLatch ? updQ[CTRL_IDX] : coreTxEn[j];
  end

  assign shiftNext = {shiftQ[LEN-2:0], tdi};

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)            shiftQ <= '0;
    else if (ctl.capEn)   shiftQ <= capVec;
    else if (ctl.shiftEn) shiftQ <= shiftNext;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)          updQ <= '0;
    else if (ctl.updEn) updQ <= shiftQ;
  end

  assign tdo = shiftQ[LEN-1];

endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int IN_PINS  = 3,
  parameter int OUT_PINS = 2
) (
  input  logic                tck,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                tdi,
  input  logic [IN_PINS-1:0]  padIn,
  output logic [IN_PINS-1:0]  coreRx,
  input  logic [OUT_PINS-1:0] coreTx,
  input  logic [OUT_PINS-1:0] coreTxEn,
  output logic [OUT_PINS-1:0] padOut,
  output logic [OUT_PINS-1:0] padOutEn,
  output logic                tdo
);

  localparam int CHAIN_LEN = IN_PINS + 2 * OUT_PINS;

  cellCtl_t             ctl;
  logic [CHAIN_LEN-1:0] shiftQ;
  logic [CHAIN_LEN-1:0] updQ;

  bsc_ctrl u_ctrl (
    .modeSel   (modeSel),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .ctl       (ctl)
  );

  bsc_datapath #(.NI(IN_PINS), .NO(OUT_PINS)) u_dp (
    .tck      (tck),
    .rstN     (rstN),
    .ctl      (ctl),
    .tdi      (tdi),
    .padIn    (padIn),
    .coreTx   (coreTx),
    .coreTxEn (coreTxEn),
    .coreRx   (coreRx),
    .padOut   (padOut),
    .padOutEn (padOutEn),
    .tdo      (tdo),
    .shiftQ   (shiftQ),
    .updQ     (updQ)
  );

endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
  parameter int NI = 3,
  parameter int NO = 2
) (
  input logic              tck,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              captureDr,
  input logic              shiftDr,
  input logic              updateDr,
  input logic              tdi,
  input logic [NI-1:0]     padIn,
  input logic [NI-1:0]     coreRx,
  input logic [NO-1:0]     coreTx,
  input logic [NO-1:0]     coreTxEn,
  input logic [NO-1:0]     padOut,
  input logic [NO-1:0]     padOutEn,
  input logic [NI+2*NO-1:0] shiftQ,
  input logic [NI+2*NO-1:0] updQ
);

  localparam int LEN = NI + 2 * NO;

  assert_strobes_exclusive_R4: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0({captureDr, shiftDr, updateDr}));

  assert_shift_step_R4: assert property (@(posedge tck) disable iff (!rstN)
    (shiftDr && modeSel != 2'b00) |=> (shiftQ == $past({shiftQ[LEN-2:0], tdi})));

  assert_capture_pads_R3: assert property (@(posedge tck) disable iff (!rstN)
    (captureDr && modeSel != 2'b00) |=> (shiftQ[NI-1:0] == $past(padIn)));

  assert_idle_hold_R2: assert property (@(posedge tck) disable iff (!rstN)
    (modeSel == 2'b00) |=> $stable(shiftQ));

  assert_func_pass_R2: assert property (@(posedge tck) disable iff (!rstN)
    (modeSel == 2'b00) |-> (padOut == coreTx && padOutEn == coreTxEn && coreRx == padIn));

  assert_latch_hold_R5: assert property (@(negedge tck) disable iff (!rstN)
    (!updateDr || modeSel == 2'b00) |=> $stable(updQ));

  assert_core_from_latch_R8: assert property (@(posedge tck) disable iff (!rstN)
    (modeSel == 2'b11) |-> (coreRx == updQ[NI-1:0]));

  for (genvar j = 0; j < NO; j++) begin : g_padChk
    assert_pad_from_latch_R7: assert property (@(posedge tck) disable iff (!rstN)
      modeSel[1] |-> (padOut[j] == updQ[NI+2*j] && padOutEn[j] == updQ[NI+2*j+1]));
  end

endmodule

bind bsc_chain bsc_chain_chk #(.NI(IN_PINS), .NO(OUT_PINS)) u_chk (
  .tck       (tck),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .captureDr (captureDr),
  .shiftDr   (shiftDr),
  .updateDr  (updateDr),
  .tdi       (tdi),
  .padIn     (padIn),
  .coreRx    (coreRx),
  .coreTx    (coreTx),
  .coreTxEn  (coreTxEn),
  .padOut    (padOut),
  .padOutEn  (padOutEn),
  .shiftQ    (shiftQ),
  .updQ      (updQ)
);

// File: tb/tb_bsc_chain.sv
module tb_bsc_chain;

  localparam int NI  = 3;
  localparam int NO  = 2;
  localparam int LEN = NI + 2 * NO;

  logic          tck = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'b00;
  logic          captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic [NI-1:0] padIn = '0;
  logic [NO-1:0] coreTx = '0, coreTxEn = '0;
  logic [NI-1:0] coreRx;
  logic [NO-1:0] padOut, padOutEn;
  logic          tdo;

  int checks = 0;
  int errors = 0;

  always #4 tck = ~tck;

  bsc_chain #(.IN_PINS(NI), .OUT_PINS(NO)) dut (
    .tck(tck), .rstN(rstN), .modeSel(modeSel),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi),
    .padIn(padIn), .coreRx(coreRx), .coreTx(coreTx), .coreTxEn(coreTxEn),
    .padOut(padOut), .padOutEn(padOutEn), .tdo(tdo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one period starting a quarter period after a rising edge
  task automatic step(input logic c, input logic s, input logic u, input logic d);
    captureDr = c; shiftDr = s; updateDr = u; tdi = d;
    #8;
    captureDr = 1'b0; shiftDr = 1'b0; updateDr = 1'b0;
  endtask

  task automatic scan(input logic [LEN-1:0] inCells, output logic [LEN-1:0] outCells);
    for (int i = 0; i < LEN; i++) begin
      outCells[LEN-1-i] = tdo;
      step(1'b0, 1'b1, 1'b0, inCells[LEN-1-i]);
    end
  endtask

  function automatic logic [NO-1:0] dataBits(input logic [LEN-1:0] c);
    for (int j = 0; j < NO; j++) dataBits[j] = c[NI+2*j];
  endfunction

  function automatic logic [NO-1:0] ctrlBits(input logic [LEN-1:0] c);
    for (int j = 0; j < NO; j++) ctrlBits[j] = c[NI+2*j+1];
  endfunction

  function automatic logic [LEN-1:0] packCap(input logic [NI-1:0] pi, input logic [NO-1:0] ct,
                                              input logic [NO-1:0] ce);
    packCap[NI-1:0] = pi;
    for (int j = 0; j < NO; j++) begin
      packCap[NI+2*j]   = ct[j];
      packCap[NI+2*j+1] = ce[j];
    end
  endfunction

  task automatic checkFunc(input string req);
    check(req, int'(padOut), int'(coreTx));
    check(req, int'(padOutEn), int'(coreTxEn));
    check(req, int'(coreRx), int'(padIn));
  endtask

  task automatic applyInputs(input int v);
    padIn    = NI'(v);
    coreTx   = NO'(v >> NI);
    coreTxEn = NO'(v >> (NI + NO));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired before completion (R1..R8 unfinished)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [LEN-1:0] got;
    logic [LEN-1:0] p1, p2;
    @(posedge tck); #2;

    // R1: reset state seen at the pads in a test mode
    modeSel = 2'b10;
    #1;
    check("R1 padOut in reset", int'(padOut), 0);
    check("R1 padOutEn in reset", int'(padOutEn), 0);
    check("R1 tdo in reset", int'(tdo), 0);
    #7;
    modeSel = 2'b01;
    rstN = 1'b1;
    #8;
    scan('0, got);
    check("R1 chain cleared", int'(got), 0);

    // R2: functional pass-through sweep
    modeSel = 2'b00;
    for (int v = 0; v < (1 << (NI + 2 * NO)); v++) begin
      applyInputs(v);
      #8;
      checkFunc("R2 pass-through");
    end

    // R3/R6: preload latches while pads stay functional
    p1 = 7'h5A;
    p2 = 7'h27;
    applyInputs(7'h33);
    modeSel = 2'b01;
    scan(p1, got);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    checkFunc("R3 pads functional after preload");

    // R2: strobes ignored in functional mode
    modeSel = 2'b00;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < LEN; i++) step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    checkFunc("R2 pass-through after strobes");
    modeSel = 2'b01;
    scan(p2, got);
    check("R2 shift stages held", int'(got), int'(p1));

    // R6: preloaded values appear on switch to external test
    modeSel = 2'b10;
    #1;
    check("R6 padOut after switch", int'(padOut), int'(dataBits(p1)));
    check("R6 padOutEn after switch", int'(padOutEn), int'(ctrlBits(p1)));
    #7;

    // R5: pads steady during shift and capture, change after update
    for (int i = 0; i < LEN; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      check("R5 padOut steady in shift", int'(padOut), int'(dataBits(p1)));
    end
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 padOutEn steady in capture", int'(padOutEn), int'(ctrlBits(p1)));
    scan(p2, got);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R5 padOut after update", int'(padOut), int'(dataBits(p2)));
    check("R5 padOutEn after update", int'(padOutEn), int'(ctrlBits(p2)));

    // R3: capture sweep in sample mode; R4: serial readout order
    modeSel = 2'b01;
    for (int v = 0; v < (1 << (NI + 2 * NO)); v++) begin
      applyInputs(v);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      checkFunc("R3 pads functional in sample");
      scan('0, got);
      check("R3 R4 captured cells", int'(got), int'(packCap(padIn, coreTx, coreTxEn)));
    end

    // R7: external test sweep over all latch patterns
    modeSel = 2'b10;
    for (int p = 0; p < (1 << LEN); p++) begin
      padIn = NI'(p ^ 5);
      scan(LEN'(p), got);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R7 padOut", int'(padOut), int'(dataBits(LEN'(p))));
      check("R7 padOutEn", int'(padOutEn), int'(ctrlBits(LEN'(p))));
      check("R7 coreRx follows pads", int'(coreRx), int'(padIn));
    end

    // R8: internal test sweep
    modeSel = 2'b11;
    for (int p = 0; p < (1 << LEN); p++) begin
      padIn = NI'(~p);
      scan(LEN'(p), got);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R8 coreRx from latches", int'(coreRx), int'(LEN'(p) & ((1 << NI) - 1)));
      check("R8 padOut from latches", int'(padOut), int'(dataBits(LEN'(p))));
    end

    // R4: a single shift moves tdi into cell 0 only
    modeSel = 2'b01;
    scan('0, got);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    scan('0, got);
    check("R4 single shift position", int'(got), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule